// File: doc/BRIEF.md
# Paged Segmentation Address Translator

This block turns a two-part logical address into a physical address. The two parts are an 18-bit segment selector and a 16-bit offset within that segment. It first reads a segment descriptor from memory. The descriptor is found at a programmable table origin plus eight bytes per segment. The block compares the offset with the segment length held in that descriptor. An offset at or beyond the length ends the translation with a bounds trap.

A legal offset is split into a 6-bit page index and a 10-bit position within a 1 KB page. The page index selects an entry in the page table of that segment, and the block reads that entry in a second memory access. A valid entry gives a frame number, and the frame joined with the in-page position forms the physical address. An entry whose valid bit is clear gives a missing-page trap instead.

One translation is in flight at a time. The requester watches `busy`, issues a one-cycle request, and takes the result on the single-cycle `done` pulse. Table reads go through a read port that holds its request until the memory acknowledges it.

Top module: `pseg_xlate`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req`, both trap flags and `resp_paddr` are all zero.
- R2: The first memory read of a translation is at byte address `table_origin + 8*segment`, where `table_origin` is the value last written through `tbl_base_wr`.
- R3: A segment descriptor carries the segment length in bits [16:0] and the page-table origin in bits [63:32]. An offset greater than or equal to the length ends the translation after exactly one memory read, with `resp_fault_len`=1, `resp_fault_page`=0 and `resp_paddr`=0.
- R4: For a legal offset, the page index is offset[15:10] and the in-page position is offset[9:0]. The second and last read is at `page_table_origin + 8*page_index`.
- R5: A page entry has its valid flag in bit 63 and its frame number in bits [19:0]. A valid entry gives `resp_paddr` = frame*1024 + in-page position, with both trap flags at 0.
- R6: A page entry with bit 63 clear gives `resp_fault_page`=1, `resp_fault_len`=0 and `resp_paddr`=0. The two trap flags are never high together.
- R7: `done` is high for exactly one cycle per accepted request, and `busy` is low in that cycle. `busy` is high from the cycle after acceptance until `done`. A `req_valid` that arrives while `busy` is high is ignored.
- R8: `mem_req` stays high with an unchanged `mem_addr` until `mem_ack`, whatever the memory latency is.
- R9: A write of the table origin affects only requests accepted after the write. A translation already in flight keeps the origin it was accepted with.
- R10: Take segment 15 with length 5096, and let page 3 of that segment sit in frame 12. Offset 3921 then translates to physical address 13137.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base_wr | input | 1 | Load strobe for the segment-table origin |
| tbl_base_wdata | input | 32 | New segment-table origin (byte address) |
| req_valid | input | 1 | Translation request, sampled when `busy` is low |
| req_seg | input | 18 | Segment selector |
| req_off | input | 16 | Offset inside the segment |
| busy | output | 1 | Translation in progress |
| done | output | 1 | One-cycle completion pulse |
| resp_paddr | output | 30 | Physical address (frame, in-page position) |
| resp_fault_len | output | 1 | Bounds trap: offset not below segment length |
| resp_fault_page | output | 1 | Missing-page trap: page entry invalid |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table read byte address |
| mem_ack | input | 1 | Read acknowledge, data valid in the same cycle |
| mem_rdata | input | 64 | Read data |

## Verification
A wrong phase register or a corrupted latched address shows up on `mem_addr` at the first or second read of the next translation. The bench records every read address and compares it with the expected descriptor and page-entry addresses. A length compare that is off by one appears as a wrong trap flag or a wrong read count at the segment boundaries, which the sweeps hit directly. A bad page/position split corrupts `resp_paddr` on the very next `done`. A lost or doubled `done`, or a request accepted while busy, shows up within one translation as a timeout or an extra read.

// File: rtl/pseg_pkg.sv
package pseg_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DESC = 2'd1,
      PH_PAGE = 2'd2
   } pseg_phase_e;

endpackage

// File: rtl/pseg_addr_gen.sv
module pseg_addr_gen #(
   parameter int IDX_W  = 18,
   parameter int ADDR_W = 32,
   parameter int SHIFT  = 3
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int SPAN_W = IDX_W + SHIFT;

   generate
      if (SPAN_W > ADDR_W) begin : g_bad_span
         $error("pseg_addr_gen: scaled index wider than address");
      end
   endgenerate

   logic [ADDR_W-1:0] scaled;
   assign scaled = ADDR_W'(idx) << SHIFT;
   assign addr   = base + scaled;
endmodule

// File: rtl/pseg_limit_split.sv
module pseg_limit_split #(
   parameter int OFF_W  = 16,
   parameter int POFF_W = 10
) (
   input  logic [OFF_W-1:0]        off,
   input  logic [OFF_W:0]          seg_len,
   output logic                    legal,
   output logic [OFF_W-POFF_W-1:0] page,
   output logic [POFF_W-1:0]       in_page
);
   generate
      if (POFF_W >= OFF_W) begin : g_bad_split
         $error("pseg_limit_split: page offset must be narrower than segment offset");
      end
   endgenerate

   assign legal   = {1'b0, off} < seg_len;
   assign page    = off[OFF_W-1:POFF_W];
   assign in_page = off[POFF_W-1:0];
endmodule

// File: rtl/pseg_xlate.sv
module pseg_xlate
   import pseg_pkg::*;
#(
   parameter int SEG_W     = 18,
   parameter int OFF_W     = 16,
   parameter int POFF_W    = 10,
   parameter int FRAME_W   = 20,
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 64,
   parameter int PTB_LSB   = 32,
   parameter int VALID_BIT = 63,
   parameter int ENT_SHIFT = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tbl_base_wr,
   input  logic [ADDR_W-1:0]         tbl_base_wdata,
   input  logic                      req_valid,
   input  logic [SEG_W-1:0]          req_seg,
   input  logic [OFF_W-1:0]          req_off,
   output logic                      busy,
   output logic                      done,
   output logic [FRAME_W+POFF_W-1:0] resp_paddr,
   output logic                      resp_fault_len,
   output logic                      resp_fault_page,
   output logic                      mem_req,
   output logic [ADDR_W-1:0]         mem_addr,
   input  logic                      mem_ack,
   input  logic [DATA_W-1:0]         mem_rdata
);
   localparam int PAGE_W = OFF_W - POFF_W;
   localparam int LEN_W  = OFF_W + 1;
   localparam int PA_W   = FRAME_W + POFF_W;

   generate
      if (PTB_LSB + ADDR_W > DATA_W) begin : g_bad_ptb
         $error("pseg_xlate: page-table origin field exceeds data word");
      end
      if (LEN_W > PTB_LSB) begin : g_bad_len
         $error("pseg_xlate: length field overlaps page-table origin");
      end
      if (FRAME_W > VALID_BIT || VALID_BIT >= DATA_W) begin : g_bad_pte
         $error("pseg_xlate: page entry layout does not fit");
      end
   endgenerate

   pseg_phase_e         phase_q;
   logic [ADDR_W-1:0]   tbl_base_q;
   logic [OFF_W-1:0]    off_q;
   logic [ADDR_W-1:0]   addr_q;
   logic                done_q;
   logic                flen_q;
   logic                fpage_q;
   logic [PA_W-1:0]     paddr_q;

   logic [ADDR_W-1:0]   desc_addr;
   logic [ADDR_W-1:0]   pte_addr;
   logic                off_legal;
   logic [PAGE_W-1:0]   page_idx;
   logic [POFF_W-1:0]   in_page;
   logic                unused_rdata;

   assign unused_rdata = ^mem_rdata;

   pseg_addr_gen #(.IDX_W(SEG_W), .ADDR_W(ADDR_W), .SHIFT(ENT_SHIFT)) desc_gen_i (
      .base (tbl_base_q),
      .idx  (req_seg),
      .addr (desc_addr)
   );

   pseg_limit_split #(.OFF_W(OFF_W), .POFF_W(POFF_W)) split_i (
      .off     (off_q),
      .seg_len (mem_rdata[LEN_W-1:0]),
      .legal   (off_legal),
      .page    (page_idx),
      .in_page (in_page)
   );

   pseg_addr_gen #(.IDX_W(PAGE_W), .ADDR_W(ADDR_W), .SHIFT(ENT_SHIFT)) pte_gen_i (
      .base (mem_rdata[PTB_LSB +: ADDR_W]),
      .idx  (page_idx),
      .addr (pte_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         tbl_base_q <= '0;
         off_q      <= '0;
         addr_q     <= '0;
         done_q     <= 1'b0;
         flen_q     <= 1'b0;
         fpage_q    <= 1'b0;
         paddr_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (tbl_base_wr) begin
            tbl_base_q <= tbl_base_wdata;
         end
         case (phase_q)
            PH_IDLE: begin
               if (req_valid) begin
                  off_q   <= req_off;
                  addr_q  <= desc_addr;
                  phase_q <= PH_DESC;
               end
            end
            PH_DESC: begin
               if (mem_ack) begin
                  if (off_legal) begin
                     addr_q  <= pte_addr;
                     phase_q <= PH_PAGE;
                  end else begin
                     done_q  <= 1'b1;
                     flen_q  <= 1'b1;
                     fpage_q <= 1'b0;
                     paddr_q <= '0;
                     phase_q <= PH_IDLE;
                  end
               end
            end
            PH_PAGE: begin
               if (mem_ack) begin
                  done_q  <= 1'b1;
                  flen_q  <= 1'b0;
                  phase_q <= PH_IDLE;
                  if (mem_rdata[VALID_BIT]) begin
                     fpage_q <= 1'b0;
                     paddr_q <= {mem_rdata[FRAME_W-1:0], in_page};
                  end else begin
                     fpage_q <= 1'b1;
                     paddr_q <= '0;
                  end
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy            = (phase_q != PH_IDLE);
   assign mem_req         = (phase_q == PH_DESC) || (phase_q == PH_PAGE);
   assign mem_addr        = addr_q;
   assign done            = done_q;
   assign resp_fault_len  = flen_q;
   assign resp_fault_page = fpage_q;
   assign resp_paddr      = paddr_q;

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_trap_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(resp_fault_len && resp_fault_page));

   assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   assert_inpage_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !resp_fault_len && !resp_fault_page) |->
         (resp_paddr[POFF_W-1:0] == off_q[POFF_W-1:0]));

   assert_trap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (resp_fault_len || resp_fault_page)) |-> (resp_paddr == '0));
endmodule

// File: tb/pseg_xlate_tb_top.sv
module pseg_xlate_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tbl_base_wr = 1'b0;
   logic [31:0] tbl_base_wdata = '0;
   logic        req_valid = 1'b0;
   logic [17:0] req_seg = '0;
   logic [15:0] req_off = '0;
   logic        busy, done, resp_fault_len, resp_fault_page, mem_req;
   logic [29:0] resp_paddr;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;

   int tests = 0;
   int fails = 0;
   int lat = 0;
   int cnt = 0;
   int rd_cnt = 0;
   logic [31:0] rd_addr [0:3];
   logic [63:0] mem [int unsigned];
   logic [31:0] cur_base = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pseg_xlate dut_i (
      .clk(clk), .rst_n(rst_n),
      .tbl_base_wr(tbl_base_wr), .tbl_base_wdata(tbl_base_wdata),
      .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
      .busy(busy), .done(done), .resp_paddr(resp_paddr),
      .resp_fault_len(resp_fault_len), .resp_fault_page(resp_fault_page),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // memory model: acknowledges after lat idle negedges
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (cnt >= lat) begin
            cnt <= 0;
            mem_ack <= 1'b1;
            mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
            if (rd_cnt < 4) rd_addr[rd_cnt] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
         end else begin
            cnt <= cnt + 1;
         end
      end
   end

   function automatic logic [63:0] rd_model(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 64'd0;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic put_seg(input logic [31:0] base, input logic [17:0] s,
                          input logic [16:0] len, input logic [31:0] ptb);
      mem[base + {11'd0, s, 3'b000}] = {ptb, 15'd0, len};
      for (int p = 0; p < 64; p++) begin
         logic        v;
         logic [19:0] fr;
         v  = ((p + int'(s)) % 5) != 4;
         fr = 20'((int'(s) * 64 + p) * 3 + 1);
         if (s == 18'd15 && p == 3) begin
            v  = 1'b1;
            fr = 20'd12;
         end
         mem[ptb + 32'(p * 8)] = {v, 43'd0, fr};
      end
   endtask

   task automatic run(input logic [17:0] s, input logic [15:0] o,
                      input bit spur, input bit wr_base, input logic [31:0] nbase);
      logic [63:0] desc, pte;
      logic [16:0] len;
      logic [31:0] daddr, paddr_pte;
      bit          got;
      desc  = rd_model(cur_base + {11'd0, s, 3'b000});
      daddr = cur_base + {11'd0, s, 3'b000};
      len   = desc[16:0];
      paddr_pte = desc[63:32] + {23'd0, o[15:10], 3'b000};
      pte   = rd_model(paddr_pte);
      @(negedge clk);
      rd_cnt = 0;
      req_valid = 1'b1; req_seg = s; req_off = o;
      @(negedge clk);
      req_valid = spur; req_seg = s ^ 18'd1; req_off = ~o;
      if (wr_base) begin tbl_base_wr = 1'b1; tbl_base_wdata = nbase; end
      check("R7 busy after accept", busy, 1);
      @(negedge clk);
      req_valid = 1'b0; tbl_base_wr = 1'b0;
      if (wr_base) cur_base = nbase;
      got = 1'b0;
      for (int i = 0; i < 100; i++) begin
         if (done) begin got = 1'b1; break; end
         @(negedge clk);
      end
      check("R7 done seen", got, 1);
      if (!got) return;
      check("R7 busy low at done", busy, 0);
      check("R2 descriptor address", rd_addr[0], daddr);
      if ({1'b0, o} >= len) begin
         check("R3 bounds trap", resp_fault_len, 1);
         check("R3 no page trap", resp_fault_page, 0);
         check("R3 single read", rd_cnt, 1);
         check("R3 paddr zero", resp_paddr, 0);
      end else begin
         check("R4 two reads", rd_cnt, 2);
         check("R4 page entry address", rd_addr[1], paddr_pte);
         check("R6 no bounds trap", resp_fault_len, 0);
         if (pte[63]) begin
            check("R5 no page trap", resp_fault_page, 0);
            check("R5 physical address", resp_paddr,
                  longint'(pte[19:0]) * 1024 + longint'(o[9:0]));
         end else begin
            check("R6 page trap", resp_fault_page, 1);
            check("R6 paddr zero", resp_paddr, 0);
         end
      end
      @(negedge clk);
      check("R7 done one cycle", done, 0);
   endtask

   initial begin
      int k;
      repeat (3) @(negedge clk);
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 mem_req", mem_req, 0);
      check("R1 traps", {resp_fault_len, resp_fault_page}, 0);
      check("R1 paddr", resp_paddr, 0);
      rst_n = 1'b1;
      @(negedge clk);
      tbl_base_wr = 1'b1; tbl_base_wdata = 32'h0010_0000;
      @(negedge clk);
      tbl_base_wr = 1'b0; cur_base = 32'h0010_0000;

      put_seg(cur_base, 18'd15, 17'd5096, 32'h0040_0000);
      put_seg(cur_base, 18'd0, 17'd0, 32'h0041_0000);
      put_seg(cur_base, 18'd1, 17'd65536, 32'h0042_0000);
      put_seg(cur_base, 18'h3FFFF, 17'd1024, 32'h0043_0000);
      put_seg(cur_base, 18'd7, 17'd1, 32'h0044_0000);

      // R10 worked example
      lat = 1;
      run(18'd15, 16'd3921, 0, 0, 0);
      check("R10 example address", resp_paddr, 13137);

      k = 0;
      for (int o = 0; o < 65536; o += 257) begin
         lat = k % 4; run(18'd1, 16'(o), (k % 3) == 0, 0, 0); k++;
      end
      run(18'd1, 16'd65535, 1, 0, 0);
      for (int o = 0; o <= 5200; o += 97) begin
         lat = k % 4; run(18'd15, 16'(o), (k % 3) == 1, 0, 0); k++;
      end
      lat = 2;
      run(18'd15, 16'd5095, 0, 0, 0);
      run(18'd15, 16'd5096, 0, 0, 0);
      run(18'd15, 16'd5097, 1, 0, 0);
      lat = 0;
      run(18'd0, 16'd0, 0, 0, 0);
      run(18'd0, 16'd100, 0, 0, 0);
      run(18'h3FFFF, 16'd1023, 0, 0, 0);
      run(18'h3FFFF, 16'd1024, 0, 0, 0);
      run(18'd7, 16'd0, 0, 0, 0);
      run(18'd7, 16'd1, 0, 0, 0);
      run(18'd9, 16'd0, 0, 0, 0);

      // R9: origin write during an in-flight translation
      put_seg(32'h0080_0000, 18'd15, 17'd100, 32'h0050_0000);
      lat = 3;
      run(18'd15, 16'd3921, 0, 1, 32'h0080_0000);
      check("R9 in-flight keeps old origin", resp_paddr, 13137);
      run(18'd15, 16'd3921, 0, 0, 0);
      check("R9 new origin bounds trap", resp_fault_len, 1);
      run(18'd15, 16'd50, 0, 0, 0);
      check("R9 new origin read", rd_addr[0], 32'h0080_0000 + 15 * 8);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule